// File: doc/BRIEF.md
# FP32-to-BF16 Narrowing Rounder

This block narrows a single-precision binary floating-point value into the 16-bit brain-float format. The narrowing is a complete rounding operation and not a bit chop. The selected rounding mode decides the discarded tail of the fraction, and all four arithmetic exception flags are judged against the 16-bit target format. Because the two formats share an 8-bit exponent field with bias 127, only fraction precision is lost. That includes the far subnormal tail between 2^-149 and 2^-134, which has no 16-bit encoding at all.

A typical user is a functional unit that computes internally in single precision and must deliver a brain-float result with the correct flags. An operand that is exact in single precision can still be inexact and tiny in the narrow format. This block raises underflow and inexact in that case, and it rounds such an operand up to the smallest subnormal when the mode requires it. The result and flags are registered, so they appear one clock after the operand is presented.

Top module: `bfn_narrow_rounder`

## Requirements
- R1: For a finite nonzero operand, the result is the operand rounded to 7 stored fraction bits, using the same 8-bit exponent with bias 127. The mode code selects the rounding: 3'b000 nearest-even, 3'b001 toward zero, 3'b010 toward negative, 3'b011 toward positive, 3'b100 nearest with ties away from zero.
- R2: Mode codes 3'b101, 3'b110 and 3'b111 produce exactly the result and flags of nearest-even.
- R3: Inexact is set for a finite operand whenever the result value differs from the operand. This includes single-precision subnormals that lie below 2^-133.
- R4: Underflow is set only when the result is tiny and inexact. Tiny means that the operand, rounded to 8 significant bits with an unbounded exponent, has a magnitude below 2^-126.
- R5: Operand 2^-140 (32'h00000200) gives 16'h0000 under nearest-even and 16'h0001 under toward-positive, with underflow and inexact set in both cases. Its negative under toward-negative gives 16'h8001.
- R6: When rounding carries the magnitude beyond the largest finite value 15'h7F7F, the result is a signed infinity and both overflow and inexact are set. A mode that rounds toward zero for the operand's sign returns the largest finite value, with inexact set and overflow clear.
- R7: A NaN operand yields 16'h7FC0. Invalid is set only when the operand is signalling, meaning fraction bit 22 is 0. No other flag is set.
- R8: Infinities and zeros pass through with their sign kept and no flags set.
- R9: Result and flags are registered, with one clock of latency. While the synchronous active-low reset is asserted, the result and all flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fp32_i | input | 32 | Single-precision operand |
| rmode_i | input | 3 | Rounding-mode code |
| bf16_o | output | 16 | Rounded brain-float result |
| flag_invalid_o | output | 1 | Signalling NaN seen |
| flag_overflow_o | output | 1 | Rounded magnitude exceeded largest finite value |
| flag_underflow_o | output | 1 | Result tiny and inexact |
| flag_inexact_o | output | 1 | Result differs from operand |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent, a 23-bit source fraction and a 7-bit target fraction. These values put the whole 16-bit discarded tail in play, including the exact half-way patterns where tie handling matters. They also reach the single-precision subnormals below 2^-133, where an exact source value must become inexact and tiny. At the other end, operands just under the largest single-precision value are reachable, so every mode can be driven across the overflow boundary. Random operands are biased toward a zero exponent, near-maximum exponents and forced ties. They are mixed with directed values around 2^-140, 2^-134, 2^-133, the minimum normal and the largest finite value.

// File: rtl/bfn_pkg.sv
// Package for the narrowing rounder: rounding-mode codes, operand classes
// and the shared round-up decision. Assumes the mode codes listed in R1.
package bfn_pkg;

    typedef enum logic [2:0] {
        RM_RNE = 3'b000,
        RM_RTZ = 3'b001,
        RM_RDN = 3'b010,
        RM_RUP = 3'b011,
        RM_RMM = 3'b100
    } rmode_e;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } cls_e;

    // Map reserved codes onto nearest-even (R2).
    function automatic rmode_e legal_mode(input logic [2:0] code);
        rmode_e m;
        if (code > 3'b100) m = RM_RNE;
        else               m = rmode_e'(code);
        return m;
    endfunction

    // Decide whether the kept magnitude is incremented.
    function automatic logic round_up(input rmode_e m, input logic sgn,
                                      input logic lsb, input logic g,
                                      input logic s);
        logic up;
        case (m)
            RM_RTZ:  up = 1'b0;
            RM_RDN:  up = sgn & (g | s);
            RM_RUP:  up = ~sgn & (g | s);
            RM_RMM:  up = g;
            default: up = g & (s | lsb);
        endcase
        return up;
    endfunction

endpackage

// File: rtl/bfn_unpack.sv
// Splits a source operand into sign, exponent and fraction and classifies it.
// Assumes IEEE-style encoding: all-ones exponent marks infinity or NaN, and
// the fraction MSB distinguishes quiet from signalling NaNs.
module bfn_unpack #(
    parameter int EXP_W    = 8,
    parameter int SRC_FRAC = 23
) (
    input  logic [EXP_W+SRC_FRAC:0] op_i,
    output logic                    sign_o,
    output logic [EXP_W-1:0]        exp_o,
    output logic [SRC_FRAC-1:0]     frac_o,
    output bfn_pkg::cls_e           cls_o,
    output logic                    snan_o
);
    import bfn_pkg::*;

    localparam int SRC_W = 1 + EXP_W + SRC_FRAC;

    // Field extraction.
    always_comb begin
        sign_o = op_i[SRC_W-1];
        exp_o  = op_i[SRC_W-2 -: EXP_W];
        frac_o = op_i[SRC_FRAC-1:0];
    end

    // Operand classification.
    always_comb begin
        snan_o = 1'b0;
        if (&exp_o) begin
            if (|frac_o) begin
                cls_o  = CLS_NAN;
                snan_o = ~frac_o[SRC_FRAC-1];
            end else begin
                cls_o  = CLS_INF;
            end
        end else if (~|exp_o && ~|frac_o) begin
            cls_o = CLS_ZERO;
        end else begin
            cls_o = CLS_FINITE;
        end
    end

endmodule

// File: rtl/bfn_round_core.sv
// Rounds a finite source magnitude to the target fraction width.
// Because both formats share the exponent field, a source subnormal maps
// directly onto the target subnormal grid with no extra shift. Also judges
// tininess after rounding with an unbounded exponent.
// Assumes SRC_FRAC - DST_FRAC >= 3.
module bfn_round_core #(
    parameter int EXP_W    = 8,
    parameter int SRC_FRAC = 23,
    parameter int DST_FRAC = 7
) (
    input  logic                   sign_i,
    input  logic [EXP_W-1:0]       exp_i,
    input  logic [SRC_FRAC-1:0]    frac_i,
    input  bfn_pkg::rmode_e        mode_i,
    output logic [EXP_W+DST_FRAC-1:0] mag_o,
    output logic                   inexact_o,
    output logic                   overflow_o,
    output logic                   tiny_o
);
    import bfn_pkg::*;

    localparam int DROP  = SRC_FRAC - DST_FRAC;
    localparam int MAG_W = EXP_W + DST_FRAC;

    logic [MAG_W-1:0] kept;
    logic             g_b, s_b, up_b;
    logic             ug, us, ulsb, reach_min_norm;

    // Bounded rounding on the target grid.
    always_comb begin
        kept      = {exp_i, frac_i[SRC_FRAC-1 -: DST_FRAC]};
        g_b       = frac_i[DROP-1];
        s_b       = |frac_i[DROP-2:0];
        up_b      = round_up(mode_i, sign_i, kept[0], g_b, s_b);
        mag_o     = kept + MAG_W'(up_b);
        inexact_o = g_b | s_b;
    end

    // Overflow: the carry drives the exponent field to all ones.
    always_comb begin
        overflow_o = &mag_o[MAG_W-1 -: EXP_W];
    end

    // Tininess after rounding with an unbounded exponent: a subnormal source
    // escapes tininess only if it rounds up to the minimum normal at full
    // target precision.
    always_comb begin
        ulsb           = frac_i[DROP-1];
        ug             = frac_i[DROP-2];
        us             = |frac_i[DROP-3:0];
        reach_min_norm = frac_i[SRC_FRAC-1]
                       & (&frac_i[SRC_FRAC-2 -: DST_FRAC])
                       & round_up(mode_i, sign_i, ulsb, ug, us);
        tiny_o         = ~|exp_i & ~reach_min_norm;
    end

endmodule

// File: rtl/bfn_narrow_rounder.sv
// Top of the narrowing rounder. Selects between the special-value paths and
// the rounding core, then registers result and flags (one-cycle latency).
// Assumes a synchronous active-low reset that clears all outputs.
module bfn_narrow_rounder #(
    parameter int EXP_W    = 8,
    parameter int SRC_FRAC = 23,
    parameter int DST_FRAC = 7,
    localparam int SRC_W   = 1 + EXP_W + SRC_FRAC,
    localparam int DST_W   = 1 + EXP_W + DST_FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] fp32_i,
    input  logic [2:0]       rmode_i,
    output logic [DST_W-1:0] bf16_o,
    output logic             flag_invalid_o,
    output logic             flag_overflow_o,
    output logic             flag_underflow_o,
    output logic             flag_inexact_o
);
    import bfn_pkg::*;

    localparam int MAG_W = EXP_W + DST_FRAC;
    localparam logic [DST_W-1:0] QNAN_C =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(DST_FRAC-1){1'b0}}};
    localparam logic [MAG_W-1:0] INF_MAG_C = {{EXP_W{1'b1}}, {DST_FRAC{1'b0}}};

    logic                sgn, snan;
    logic [EXP_W-1:0]    expf;
    logic [SRC_FRAC-1:0] frac;
    cls_e                cls;
    rmode_e              mode;
    logic [MAG_W-1:0]    mag;
    logic                nx_c, of_c, tiny_c;
    logic [DST_W-1:0]    res_d;
    logic                nv_d, of_d, uf_d, nx_d;

    bfn_unpack #(.EXP_W(EXP_W), .SRC_FRAC(SRC_FRAC)) unpack_i (
        .op_i   (fp32_i),
        .sign_o (sgn),
        .exp_o  (expf),
        .frac_o (frac),
        .cls_o  (cls),
        .snan_o (snan)
    );

    // Resolve the mode code, folding reserved codes onto nearest-even.
    always_comb begin
        mode = legal_mode(rmode_i);
    end

    bfn_round_core #(.EXP_W(EXP_W), .SRC_FRAC(SRC_FRAC), .DST_FRAC(DST_FRAC)) core_i (
        .sign_i     (sgn),
        .exp_i      (expf),
        .frac_i     (frac),
        .mode_i     (mode),
        .mag_o      (mag),
        .inexact_o  (nx_c),
        .overflow_o (of_c),
        .tiny_o     (tiny_c)
    );

    // Choose result and flags by operand class.
    always_comb begin
        res_d = {sgn, mag};
        nv_d  = 1'b0;
        of_d  = 1'b0;
        uf_d  = 1'b0;
        nx_d  = 1'b0;
        case (cls)
            CLS_NAN: begin
                res_d = QNAN_C;
                nv_d  = snan;
            end
            CLS_INF, CLS_ZERO: begin
                res_d = {sgn, expf, frac[SRC_FRAC-1 -: DST_FRAC]};
            end
            default: begin
                of_d = of_c;
                uf_d = tiny_c & nx_c;
                nx_d = nx_c;
            end
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bf16_o           <= '0;
            flag_invalid_o   <= 1'b0;
            flag_overflow_o  <= 1'b0;
            flag_underflow_o <= 1'b0;
            flag_inexact_o   <= 1'b0;
        end else begin
            bf16_o           <= res_d;
            flag_invalid_o   <= nv_d;
            flag_overflow_o  <= of_d;
            flag_underflow_o <= uf_d;
            flag_inexact_o   <= nx_d;
        end
    end

    AST_UF_NEEDS_NX: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow_o |-> flag_inexact_o); // R4
    AST_OF_GIVES_INF: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow_o |-> (bf16_o[MAG_W-1:0] == INF_MAG_C && flag_inexact_o)); // R6
    AST_INVALID_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid_o |-> (bf16_o == QNAN_C && !flag_inexact_o)); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_invalid_o, flag_overflow_o, flag_underflow_o})); // R6
    AST_STABLE_IN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fp32_i) && $stable(rmode_i) && $past(rst_n)) |=> $stable(bf16_o)); // R9

endmodule

// File: tb/bfn_narrow_rounder_tb.sv
// Self-checking bench: directed corners plus seeded random operands,
// compared against a reference computed from the requirements.
module bfn_narrow_rounder_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fp32_i;
    logic [2:0]  rmode_i;
    logic [15:0] bf16_o;
    logic        flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfn_narrow_rounder dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .fp32_i           (fp32_i),
        .rmode_i          (rmode_i),
        .bf16_o           (bf16_o),
        .flag_invalid_o   (flag_invalid_o),
        .flag_overflow_o  (flag_overflow_o),
        .flag_underflow_o (flag_underflow_o),
        .flag_inexact_o   (flag_inexact_o)
    );

    // cmp: 0 below half, 1 exact half, 2 above half (remainder nonzero).
    function automatic bit decide(input int m, input bit s, input bit lsb, input int cmp);
        case (m)
            1: return 1'b0;
            2: return s;
            3: return !s;
            4: return cmp >= 1;
            default: return (cmp == 2) || (cmp == 1 && lsb);
        endcase
    endfunction

    // Reference: {result[15:0], invalid, overflow, underflow, inexact}.
    function automatic logic [19:0] ref_model(input logic [31:0] x, input logic [2:0] rm);
        bit          s = x[31];
        logic [7:0]  e = x[30:23];
        logic [22:0] f = x[22:0];
        logic [14:0] lo;
        logic [15:0] rem;
        logic [15:0] mag;
        int m, cmp, p, sh, q, r, half, big;
        bit up, of, tiny;
        m = (rm > 3'd4) ? 0 : int'(rm);
        if (e == 8'hFF && f != 0) return {16'h7FC0, !f[22], 3'b000};
        if (e == 8'hFF || (e == 0 && f == 0)) return {x[31:16], 4'b0000};
        lo  = x[30:16];
        rem = x[15:0];
        if (rem == 16'h0000) return {x[31:16], 4'b0000};
        cmp = (rem < 16'h8000) ? 0 : ((rem == 16'h8000) ? 1 : 2);
        up  = decide(m, s, lo[0], cmp);
        mag = {1'b0, lo} + 16'(up);
        of  = (mag[14:7] == 8'hFF);
        tiny = 1'b0;
        if (e == 0) begin
            // Round the subnormal to 8 significant bits on an unbounded exponent.
            p = 0;
            for (int i = 0; i < 23; i++) if (f[i]) p = i;
            big = int'(f);
            if (p <= 7) begin
                tiny = 1'b1;
            end else begin
                sh   = p - 7;
                q    = big >> sh;
                r    = big & ((1 << sh) - 1);
                half = 1 << (sh - 1);
                if (r == 0) up = 1'b0;
                else up = decide(m, s, q[0], (r < half) ? 0 : ((r == half) ? 1 : 2));
                tiny = ((q + int'(up)) << sh) < (1 << 23);
            end
        end
        return {s, mag[14:0], 1'b0, of, tiny, 1'b1};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register).
    task automatic apply(input logic [31:0] x, input logic [2:0] rm, input string tag);
        logic [19:0] exp_v, act;
        @(negedge clk);
        fp32_i  = x;
        rmode_i = rm;
        @(negedge clk);
        exp_v = ref_model(x, rm);
        act   = {bf16_o, flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s op=%h rm=%0d actual=%h/%b expected=%h/%b",
                     tag, x, rm, act[19:4], act[3:0], exp_v[19:4], exp_v[3:0]);
        end
    endtask

    task automatic expect_exact(input logic [31:0] x, input logic [2:0] rm,
                                input logic [19:0] want, input string tag);
        logic [19:0] act;
        @(negedge clk);
        fp32_i  = x;
        rmode_i = rm;
        @(negedge clk);
        act = {bf16_o, flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o};
        checks++;
        if (act !== want) begin
            failures++;
            $display("FAIL %s op=%h rm=%0d actual=%h/%b expected=%h/%b",
                     tag, x, rm, act[19:4], act[3:0], want[19:4], want[3:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n   = 1'b0;
        fp32_i  = 32'h3F80_0000;
        rmode_i = 3'd0;
        repeat (3) @(negedge clk);
        // R9: reset clears result and flags even with a live operand.
        checks++;
        if ({bf16_o, flag_invalid_o, flag_overflow_o, flag_underflow_o, flag_inexact_o} !== 20'h0) begin
            failures++;
            $display("FAIL R9 reset actual=%h expected=0", bf16_o);
        end
        rst_n = 1'b1;

        // R5: 2^-140 corner in several modes.
        expect_exact(32'h0000_0200, 3'd0, {16'h0000, 4'b0011}, "R5 rne");
        expect_exact(32'h0000_0200, 3'd3, {16'h0001, 4'b0011}, "R5 rup");
        expect_exact(32'h8000_0200, 3'd2, {16'h8001, 4'b0011}, "R5 rdn neg");
        expect_exact(32'h0000_0200, 3'd1, {16'h0000, 4'b0011}, "R3 rtz tail");
        // R3/R4: exact smallest subnormal, tie at 2^-134.
        expect_exact(32'h0001_0000, 3'd0, {16'h0001, 4'b0000}, "R3 exact 2^-133");
        expect_exact(32'h0000_8000, 3'd0, {16'h0000, 4'b0011}, "R4 tie 2^-134 rne");
        expect_exact(32'h0000_8000, 3'd4, {16'h0001, 4'b0011}, "R4 tie 2^-134 rmm");
        // R4: just below minimum normal, rounds up (not tiny) vs truncated (tiny).
        expect_exact(32'h007F_FFFF, 3'd0, {16'h0080, 4'b0001}, "R4 reach min normal");
        expect_exact(32'h007F_FFFF, 3'd1, {16'h007F, 4'b0011}, "R4 rtz stays tiny");
        // R6: largest finite boundary.
        expect_exact(32'h7F7F_FFFF, 3'd0, {16'h7F80, 4'b0101}, "R6 rne overflow");
        expect_exact(32'h7F7F_FFFF, 3'd1, {16'h7F7F, 4'b0001}, "R6 rtz saturate");
        expect_exact(32'h7F7F_FFFF, 3'd2, {16'h7F7F, 4'b0001}, "R6 rdn pos saturate");
        expect_exact(32'hFF7F_FFFF, 3'd2, {16'hFF80, 4'b0101}, "R6 rdn neg overflow");
        expect_exact(32'hFF7F_FFFF, 3'd3, {16'hFF7F, 4'b0001}, "R6 rup neg saturate");
        // R1: exact ties in the normal range.
        expect_exact(32'h3F80_8000, 3'd0, {16'h3F80, 4'b0001}, "R1 tie even down");
        expect_exact(32'h3F81_8000, 3'd0, {16'h3F82, 4'b0001}, "R1 tie even up");
        expect_exact(32'hBF80_8000, 3'd4, {16'hBF81, 4'b0001}, "R1 tie away");
        // R2: reserved codes act as nearest-even.
        expect_exact(32'h3F81_8000, 3'd5, {16'h3F82, 4'b0001}, "R2 code5");
        expect_exact(32'h0000_8000, 3'd7, {16'h0000, 4'b0011}, "R2 code7");
        // R7: NaNs.
        expect_exact(32'h7F80_0001, 3'd0, {16'h7FC0, 4'b1000}, "R7 snan");
        expect_exact(32'hFFC0_0000, 3'd3, {16'h7FC0, 4'b0000}, "R7 qnan");
        // R8: infinities and zeros.
        expect_exact(32'hFF80_0000, 3'd1, {16'hFF80, 4'b0000}, "R8 -inf");
        expect_exact(32'h8000_0000, 3'd3, {16'h8000, 4'b0000}, "R8 -zero");

        // Mode sweep at the subnormal boundaries.
        for (int md = 0; md < 8; md++) begin
            apply(32'h0001_0001, 3'(md), "R1 above 2^-133");
            apply(32'h0000_FFFF, 3'(md), "R4 below 2^-133");
            apply(32'h8000_8001, 3'(md), "R4 above 2^-134 neg");
            apply(32'h7F7F_8000, 3'(md), "R6 max tie");
        end

        // Seeded random operands with biased exponents and forced ties.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] x;
            int kind;
            x    = $urandom;
            kind = int'($urandom % 8);
            case (kind)
                0: x[30:23] = 8'h00;
                1: x[30:23] = 8'hFE;
                2: x[30:23] = 8'hFF;
                default: ;
            endcase
            if ($urandom % 4 == 0) x[15:0] = 16'h8000;
            apply(x, 3'($urandom % 8), "R1 random");
        end

        done = 1'b1;
        finish_run();
    end

endmodule